// File: doc/BRIEF.md
# Accumulator ALU with Flag Update Control

This block is the combinational arithmetic and logic unit of a small 8-bit accumulator machine. In each cycle the sequencer gives it an opcode, the current accumulator, an already fetched operand byte and the current carry flag. The block returns the new result byte and a write strobe for the accumulator. For each of the four condition flags (negative, zero, carry, overflow) it returns a new value and an update enable.

Each operation has its own rule for the flags. It may set a flag, clear it or leave it alone. The enables let the surrounding register file keep the flags that an operation does not touch. A compare runs the subtraction and updates every flag, but it leaves the accumulator unchanged. The carry flag means a borrow after a subtraction or a compare. Opcodes this block does not own give no write and no flag update, so the neighbouring decode can route them elsewhere.

Top module: `acc_alu`

## Requirements
- R1: Opcode 03h gives the bitwise inverse of the accumulator with a write. It updates N and Z, clears V and leaves C alone (c_we=0).
- R2: Opcodes 04h and 05h give accumulator plus one and minus one, modulo 256, with a write. Only N and Z are updated (c_we=0, v_we=0).
- R3: Opcode 06h shifts left, 07h shifts right logically, and 08h shifts right while keeping bit 7. Carry receives the bit shifted out: bit 7 for the left shift, bit 0 for both right shifts. V is cleared and N, Z are updated.
- R4: Opcodes 23h–25h add the operand and 26h–28h add the operand plus carry-in. C is set on an unsigned carry out of bit 7. V is set when both inputs share a sign that differs from the result sign.
- R5: Opcodes 29h–2Bh subtract the operand and 2Ch–2Eh subtract the operand and the carry-in. C is set when a borrow occurs. V is set when the input signs differ and the result sign differs from the accumulator sign.
- R6: Opcodes 2Fh–31h compute the plain subtraction (carry-in ignored) and update N, Z, C and V as R5 does. acc_we is 0.
- R7: Opcodes 32h–34h give the AND and 35h–37h give the OR of accumulator and operand with a write. V is cleared, N and Z are updated and C is left alone.
- R8: Whenever N and Z are updated, N equals bit 7 of the 8-bit result and Z is set exactly when that result is zero.
- R9: Every other opcode in 00h–7Fh gives acc_we=0 and all four flag enables 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 7 | Operation code |
| acc_in | input | 8 | Current accumulator |
| opnd_in | input | 8 | Operand byte |
| c_in | input | 1 | Current carry flag |
| res_out | output | 8 | Result byte (subtraction result for compare) |
| acc_we | output | 1 | Accumulator write enable |
| n_out | output | 1 | New negative flag |
| z_out | output | 1 | New zero flag |
| c_out | output | 1 | New carry/borrow flag |
| v_out | output | 1 | New overflow flag |
| n_we | output | 1 | Negative flag update enable |
| z_we | output | 1 | Zero flag update enable |
| c_we | output | 1 | Carry flag update enable |
| v_we | output | 1 | Overflow flag update enable |

## Verification
Additions and subtractions are driven at the signed boundary (7Fh+1, 80h−1), at the unsigned boundary (FFh+1, 00h−1) and with carry-in both set and clear. These cases tell signed overflow apart from unsigned carry and borrow, and they expose a carry-in that is wrongly used or wrongly dropped. Shifts use bytes with bit 0 and bit 7 set and clear, which tells the logical right shift apart from the arithmetic one and checks which bit lands in carry. Compare is run with equal inputs and with carry-in set, to show that the accumulator is never written and that carry-in has no effect. Unowned opcodes and a pseudo-random sweep round this out.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W   = 8,
  parameter int OPW = 7
) (
  input  logic [OPW-1:0] op_sel,
  input  logic [W-1:0]   acc_in,
  input  logic [W-1:0]   opnd_in,
  input  logic           c_in,
  output logic [W-1:0]   res_out,
  output logic           acc_we,
  output logic           n_out,
  output logic           z_out,
  output logic           c_out,
  output logic           v_out,
  output logic           n_we,
  output logic           z_we,
  output logic           c_we,
  output logic           v_we
);
  localparam int MSB = W - 1;
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic is_inv, is_inc, is_dec, is_shl, is_shr, is_asr;
  logic is_add, is_sub, is_cmp, is_and, is_or;
  logic with_c, shift, logic_op, owned;
  logic [W:0] add_w, sub_w;
  logic add_ov, sub_ov;

  assign is_inv = op_sel == OPW'(8'h03);
  assign is_inc = op_sel == OPW'(8'h04);
  assign is_dec = op_sel == OPW'(8'h05);
  assign is_shl = op_sel == OPW'(8'h06);
  assign is_shr = op_sel == OPW'(8'h07);
  assign is_asr = op_sel == OPW'(8'h08);
  assign is_add = op_sel >= OPW'(8'h23) && op_sel <= OPW'(8'h28);
  assign is_sub = op_sel >= OPW'(8'h29) && op_sel <= OPW'(8'h2E);
  assign is_cmp = op_sel >= OPW'(8'h2F) && op_sel <= OPW'(8'h31);
  assign is_and = op_sel >= OPW'(8'h32) && op_sel <= OPW'(8'h34);
  assign is_or  = op_sel >= OPW'(8'h35) && op_sel <= OPW'(8'h37);
  assign with_c = (is_add && op_sel >= OPW'(8'h26)) || (is_sub && op_sel >= OPW'(8'h2C));

  assign shift    = is_shl | is_shr | is_asr;
  assign logic_op = is_inv | is_and | is_or;

  assign add_w  = {1'b0, acc_in} + {1'b0, opnd_in} + {{W{1'b0}}, with_c & c_in};
  assign sub_w  = {1'b0, acc_in} - {1'b0, opnd_in} - {{W{1'b0}}, with_c & c_in};
  assign add_ov = (acc_in[MSB] == opnd_in[MSB]) && (add_w[MSB] != acc_in[MSB]);
  assign sub_ov = (acc_in[MSB] != opnd_in[MSB]) && (sub_w[MSB] != acc_in[MSB]);

  always_comb begin
    res_out = '0;
    if (is_inv)               res_out = ~acc_in;
    else if (is_inc)          res_out = acc_in + ONE;
    else if (is_dec)          res_out = acc_in - ONE;
    else if (is_shl)          res_out = {acc_in[MSB-1:0], 1'b0};
    else if (is_shr)          res_out = {1'b0, acc_in[MSB:1]};
    else if (is_asr)          res_out = {acc_in[MSB], acc_in[MSB:1]};
    else if (is_add)          res_out = add_w[W-1:0];
    else if (is_sub | is_cmp) res_out = sub_w[W-1:0];
    else if (is_and)          res_out = acc_in & opnd_in;
    else if (is_or)           res_out = acc_in | opnd_in;
  end

  assign acc_we = logic_op | is_inc | is_dec | shift | is_add | is_sub;
  assign owned  = acc_we | is_cmp;
  assign n_we   = owned;
  assign z_we   = owned;
  assign c_we   = shift | is_add | is_sub | is_cmp;
  assign v_we   = shift | is_add | is_sub | is_cmp | logic_op;

  assign n_out = res_out[MSB];
  assign z_out = res_out == '0;
  assign c_out = is_shl ? acc_in[MSB] :
                 (is_shr | is_asr) ? acc_in[0] :
                 is_add ? add_w[W] : sub_w[W];
  assign v_out = is_add ? add_ov : (is_sub | is_cmp) ? sub_ov : 1'b0;

  always_comb begin
    if (is_inv) AST_INV_BITS: assert ((res_out ^ acc_in) == '1 && !c_we && !v_out) else $error("inv"); // R1
    if (is_inc | is_dec) AST_STEP_NZ_ONLY: assert (!c_we && !v_we && n_we) else $error("step"); // R2
    if (is_shl) AST_SHL_CARRY: assert (c_out == acc_in[MSB] && !v_out && c_we) else $error("shl"); // R3
    if (is_cmp) AST_CMP_HOLD_ACC: assert (!acc_we && c_we && v_we) else $error("cmp"); // R6
    if (is_and | is_or) AST_LOGIC_KEEP_C: assert (!c_we && v_we && !v_out) else $error("logic"); // R7
    if (!acc_we) AST_IDLE_NO_FLAGS: assert (is_cmp || !(n_we | z_we | c_we | v_we)) else $error("idle"); // R9
  end
endmodule

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0] res;
    logic we, n, z, c, v, nwe, zwe, cwe, vwe;
    logic [7:0] op;
    int tag;
  } exp_t;

  logic clk = 0, rst = 1;
  logic [6:0] op_sel = '0;
  logic [7:0] acc_in = '0, opnd_in = '0;
  logic c_in = 0;
  logic [7:0] res_out;
  logic acc_we, n_out, z_out, c_out, v_out, n_we, z_we, c_we, v_we;
  int total = 0, bad = 0;
  bit done = 0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_alu u_acc_alu (
    .op_sel(op_sel), .acc_in(acc_in), .opnd_in(opnd_in), .c_in(c_in),
    .res_out(res_out), .acc_we(acc_we), .n_out(n_out), .z_out(z_out),
    .c_out(c_out), .v_out(v_out), .n_we(n_we), .z_we(z_we), .c_we(c_we), .v_we(v_we)
  );

  function automatic int sgn(int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  function automatic exp_t model(int op, int a, int b, int ci, int tag);
    exp_t e;
    int r, s, sr, k;
    e = '0; e.op = 8'(op); e.tag = tag; r = 0;
    if (op == 3) begin r = 255 - a; e.we = 1; e.nwe = 1; e.zwe = 1; e.vwe = 1; end
    else if (op == 4 || op == 5) begin
      r = (op == 4) ? (a + 1) % 256 : (a + 255) % 256; e.we = 1; e.nwe = 1; e.zwe = 1;
    end else if (op >= 6 && op <= 8) begin
      if (op == 6) begin r = (a * 2) % 256; e.c = a >= 128; end
      else begin r = a / 2 + ((op == 8) ? (a / 128) * 128 : 0); e.c = (a % 2) == 1; end
      e.we = 1; e.nwe = 1; e.zwe = 1; e.cwe = 1; e.vwe = 1;
    end else if (op >= 'h23 && op <= 'h28) begin
      k = (op >= 'h26) ? ci : 0;
      s = a + b + k; r = s % 256; e.c = s > 255;
      sr = sgn(a) + sgn(b) + k; e.v = sr > 127 || sr < -128;
      e.we = 1; e.nwe = 1; e.zwe = 1; e.cwe = 1; e.vwe = 1;
    end else if (op >= 'h29 && op <= 'h31) begin
      k = (op >= 'h2C && op <= 'h2E) ? ci : 0;
      s = a - b - k; r = (s + 512) % 256; e.c = s < 0;
      sr = sgn(a) - sgn(b) - k; e.v = sr > 127 || sr < -128;
      e.we = (op < 'h2F); e.nwe = 1; e.zwe = 1; e.cwe = 1; e.vwe = 1;
    end else if (op >= 'h32 && op <= 'h37) begin
      r = (op <= 'h34) ? (a & b) : (a | b);
      e.we = 1; e.nwe = 1; e.zwe = 1; e.vwe = 1;
    end
    e.res = 8'(r); e.n = r >= 128; e.z = r == 0;
    return e;
  endfunction

  task automatic drive(int op, int a, int b, int ci, int tag);
    @(negedge clk);
    op_sel = 7'(op); acc_in = 8'(a); opnd_in = 8'(b); c_in = ci[0];
    q.push_back(model(op, a, b, ci, tag));
  endtask

  always @(posedge clk) begin
    if (!rst && q.size() > 0) begin
      exp_t e;
      bit ok;
      e = q.pop_front();
      ok = (acc_we == e.we) && (n_we == e.nwe) && (z_we == e.zwe) && (c_we == e.cwe) && (v_we == e.vwe);
      if (e.we || e.nwe) ok = ok && res_out == e.res;
      if (e.nwe) ok = ok && n_out == e.n && z_out == e.z; // R8
      if (e.cwe) ok = ok && c_out == e.c;
      if (e.vwe) ok = ok && v_out == e.v;
      total++;
      if (!ok) begin
        bad++;
        $display("FAIL R%0d op=%02h got res=%02h we=%b nzcv=%b%b%b%b en=%b%b%b%b exp res=%02h we=%b nzcv=%b%b%b%b en=%b%b%b%b",
          e.tag, e.op, res_out, acc_we, n_out, z_out, c_out, v_out, n_we, z_we, c_we, v_we,
          e.res, e.we, e.n, e.z, e.c, e.v, e.nwe, e.zwe, e.cwe, e.vwe);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    repeat (3) @(posedge clk);
    #1;
    total++; // R9 idle state after reset with opcode 00h
    if (acc_we || n_we || z_we || c_we || v_we) begin
      bad++;
      $display("FAIL R9 reset idle got we=%b en=%b%b%b%b exp all 0", acc_we, n_we, z_we, c_we, v_we);
    end
    rst = 0;
    drive('h03, 'h00, 0, 1, 1); drive('h03, 'h5A, 0, 0, 1);          // R1
    drive('h04, 'h7F, 0, 1, 2); drive('h04, 'hFF, 0, 0, 2);          // R2
    drive('h05, 'h00, 0, 1, 2); drive('h05, 'h01, 0, 0, 2);          // R2
    drive('h06, 'h81, 0, 0, 3); drive('h07, 'h01, 0, 0, 3);          // R3
    drive('h08, 'h81, 0, 0, 3); drive('h08, 'h40, 0, 1, 3);          // R3
    drive('h07, 'h80, 0, 1, 3);                                      // R3
    drive('h23, 'h7F, 'h01, 1, 4); drive('h25, 'hFF, 'h01, 0, 4);    // R4
    drive('h26, 'h10, 'h20, 1, 4); drive('h28, 'hFF, 'h00, 1, 4);    // R4
    drive('h24, 'h80, 'h80, 0, 4);                                   // R4
    drive('h29, 'h80, 'h01, 1, 5); drive('h2B, 'h00, 'h01, 0, 5);    // R5
    drive('h2C, 'h05, 'h05, 1, 5); drive('h2E, 'h7F, 'hFF, 0, 5);    // R5
    drive('h2F, 'h42, 'h42, 1, 6); drive('h31, 'h03, 'h05, 0, 6);    // R6
    drive('h30, 'h80, 'h7F, 1, 6);                                   // R6
    drive('h32, 'hF0, 'h0F, 1, 7); drive('h34, 'hF3, 'h81, 0, 7);    // R7
    drive('h35, 'h00, 'h00, 1, 7); drive('h37, 'h40, 'h21, 0, 7);    // R7
    drive('h00, 'h12, 'h34, 1, 9); drive('h01, 'h80, 'h80, 1, 9);    // R9
    drive('h10, 'hFF, 'hFF, 0, 9); drive('h38, 'h00, 'h00, 1, 9);    // R9
    drive('h22, 'h01, 'h01, 1, 9); drive('h7F, 'h55, 'hAA, 1, 9);    // R9
    seed = 7;
    for (int i = 0; i < 600; i++) begin                              // R8 sweep
      int op, a, b;
      seed = (seed * 1103515245 + 12345) & 32'h7FFFFFFF;
      op = (seed >> 4) % 64; a = (seed >> 10) % 256; b = (seed >> 18) % 256;
      drive(op, a, b, (seed >> 27) & 1, 8);
    end
    while (q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule